// File: doc/BRIEF.md
# Dual Compare/Capture PWM Timer

A 16-bit up-counter advanced by a count-enable tick, paired with two data registers, A and B. Each register works either as a comparator against the counter or as a capture latch that stores the counter value on a chosen edge of its own external input. When B compares, the counter returns to zero after the tick on which it equals B, so B sets the period. A sets the duty point.

Two waveform outputs are derived from the matches. Each output can be held off, set by an A match and cleared by a B match, or toggled by its own register's match. Each output can also be inverted. Compare values can pass through shadow copies that take new software values only at the period boundary. Six sticky cause flags (two compare, two capture, two capture-overwrite) are masked into one interrupt request. Software drives the block through a small word-wide register port with write strobes and combinational read data.

Top module: `pwm_cc_timer`

## Requirements
- R1: After reset the counter, control, mode, flag and enable registers read 0, both outputs are low and `irq_o` is low.
- R2: With the run bit (control bit 0) at 1, each clock edge with `tick_i` high adds one to the counter. The counter holds when `tick_i` is low or the run bit is 0.
- R3: With B comparing, the tick on which the counter equals B sends it to 0. With B capturing, the counter wraps from 0xFFFF to 0.
- R4: A tick on which the counter equals a comparing register sets flag bit 0 (A) or bit 1 (B). The flag is readable after that edge.
- R5: Output mode 1 sets the output on an A match and clears it on a B match. A B match wins. With B comparing and effective A greater than or equal to B, the A match does not set the output.
- R6: Output mode 2 toggles output A on an A match and output B on a B match. Mode 0 holds the output at its inactive level.
- R7: Inversion bits (mode bits 10 and 11, for A and B) invert the output, so an idle output reads 1.
- R8: Mode bit 0 (A) or 1 (B) at 1 selects capture. Its trigger field (bits 3:2 for A, 5:4 for B) selects the edge: 0 none, 1 rising, 2 falling, 3 both. The counter value is latched on the third clock edge after the input changes, and flag bit 2 (A) or 3 (B) is set. In comparator mode, input edges change neither the register nor the flags.
- R9: A capture that occurs while its capture flag is still set also sets flag bit 4 (A) or 5 (B).
- R10: With control bit 2 at 1, matches and the period use shadow copies. The shadows load from the registers when the counter wraps or is cleared. With bit 2 at 0, written values take effect at once.
- R11: Writing 1 to a flag bit at address 5 clears that bit, and writing 0 leaves it unchanged. `irq_o` is the OR of the flags ANDed with the enable register at address 6.
- R12: Writing 1 to control bit 1 zeroes the counter and both waveform states on that edge. The bit always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count enable |
| cap_a_i | input | 1 | Capture input for register A |
| cap_b_i | input | 1 | Capture input for register B |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 control, 1 mode, 2 A, 3 B, 4 counter, 5 flags, 6 enables |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Combinational read data for `reg_addr_i` |
| pwm_a_o | output | 1 | Waveform output A |
| pwm_b_o | output | 1 | Waveform output B |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter, the compare flags, the waveform outputs and the interrupt line all change on the same edge that samples a qualifying tick. Each capture result lands on the third edge after its input moves: two edges of synchronisation and one for the latch. The bench drives stimulus on falling edges and samples on the following falling edge, one edge later for the counter-driven results. For captures it waits three falling edges and also samples after two, to confirm that nothing lands early. A cycle-stepped bench model, fed the same random tick pattern, supplies the expected counter, flags and output levels for every sampled cycle.

// File: rtl/pwm_cc_pkg.sv
package pwm_cc_pkg;

  typedef enum logic [1:0] {
    OUT_OFF    = 2'd0,
    OUT_SETRST = 2'd1,
    OUT_TOGGLE = 2'd2,
    OUT_RSVD   = 2'd3
  } out_mode_e;

  typedef enum logic [1:0] {
    TRIG_NONE = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_FALL = 2'd2,
    TRIG_BOTH = 2'd3
  } trig_e;

  typedef struct packed {
    logic      inv_b;
    logic      inv_a;
    out_mode_e out_b;
    out_mode_e out_a;
    trig_e     trig_b;
    trig_e     trig_a;
    logic      cap_b;
    logic      cap_a;
  } mode_t;

  localparam int ADDR_W = 3;
  localparam int NFLAG  = 6;
  localparam int NCH    = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_MODE  = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_CMPA  = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_CMPB  = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_COUNT = 3'd4;
  localparam logic [ADDR_W-1:0] ADR_FLAGS = 3'd5;
  localparam logic [ADDR_W-1:0] ADR_IEN   = 3'd6;

endpackage

// File: rtl/pwm_cc_capture_edge.sv
module pwm_cc_capture_edge
  import pwm_cc_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_i,
  input  trig_e trig_i,
  output logic  event_o
);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              lvl, rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign lvl  = sync_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;

  always_comb begin
    unique case (trig_i)
      TRIG_RISE: event_o = rise;
      TRIG_FALL: event_o = fall;
      TRIG_BOTH: event_o = rise | fall;
      default:   event_o = 1'b0;
    endcase
  end

  a_r8_rise_needs_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_o && trig_i == TRIG_RISE) |=> prev_q);

endmodule

// File: rtl/pwm_cc_counter.sv
module pwm_cc_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         clr_i,
  input  logic         use_period_i,
  input  logic [W-1:0] period_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;
  logic         step, at_end;

  assign step   = run_i & tick_i;
  assign at_end = use_period_i ? (cnt_q == period_i) : (cnt_q == '1);
  assign wrap_o = step & at_end & ~clr_i;
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (step)  cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  a_r2_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run_i && tick_i) && !clr_i) |=> $stable(cnt_q));

  a_r2_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !clr_i && !wrap_o) |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r12_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0);

endmodule

// File: rtl/pwm_cc_wave.sv
module pwm_cc_wave
  import pwm_cc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  out_mode_e mode_i,
  input  logic      inv_i,
  input  logic      clr_i,
  input  logic      set_i,
  input  logic      rst_i,
  input  logic      tog_i,
  output logic      out_o
);

  logic raw_q, raw_d;

  always_comb begin
    raw_d = raw_q;
    if (clr_i) raw_d = 1'b0;
    else begin
      unique case (mode_i)
        OUT_SETRST: raw_d = rst_i ? 1'b0 : (set_i ? 1'b1 : raw_q);
        OUT_TOGGLE: raw_d = tog_i ? ~raw_q : raw_q;
        default:    raw_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_q <= 1'b0;
    else         raw_q <= raw_d;
  end

  assign out_o = raw_q ^ inv_i;

  a_r5_no_rise_without_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OUT_SETRST && !set_i) |=> !$rose(raw_q));

  a_r6_off_stays_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == OUT_OFF) |=> !raw_q);

endmodule

// File: rtl/pwm_cc_timer.sv
module pwm_cc_timer
  import pwm_cc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              cap_a_i,
  input  logic              cap_b_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              pwm_a_o,
  output logic              pwm_b_o,
  output logic              irq_o
);

  localparam int MODE_W = $bits(mode_t);

  logic             run_q, bufen_q;
  mode_t            mode_q;
  logic [CNT_W-1:0] cmp_q    [NCH];
  logic [CNT_W-1:0] shadow_q [NCH];
  logic [CNT_W-1:0] eff      [NCH];
  logic [NFLAG-1:0] flags_q, flag_set, w1c;
  logic [NFLAG-1:0] ien_q;

  logic [CNT_W-1:0] cnt;
  logic             wrap, clr, suppress;
  logic [NCH-1:0]   cap_mode, edge_evt, cap_evt, match, ovw, inv_sel, pins, pwm;
  trig_e            trig_sel [NCH];
  out_mode_e        out_sel  [NCH];

  assign clr = reg_we_i && reg_addr_i == ADR_CTRL && reg_wdata_i[1];

  assign cap_mode    = {mode_q.cap_b, mode_q.cap_a};
  assign inv_sel     = {mode_q.inv_b, mode_q.inv_a};
  assign pins        = {cap_b_i, cap_a_i};
  assign trig_sel[0] = mode_q.trig_a;
  assign trig_sel[1] = mode_q.trig_b;
  assign out_sel[0]  = mode_q.out_a;
  assign out_sel[1]  = mode_q.out_b;

  always_comb begin
    for (int i = 0; i < NCH; i++) eff[i] = bufen_q ? shadow_q[i] : cmp_q[i];
  end

  pwm_cc_counter #(.W(CNT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .tick_i      (tick_i),
    .clr_i       (clr),
    .use_period_i(~cap_mode[1]),
    .period_i    (eff[1]),
    .cnt_o       (cnt),
    .wrap_o      (wrap)
  );

  // rise event blocked when duty point is at or past the period end
  assign suppress = ~cap_mode[1] & (eff[0] >= eff[1]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pwm_cc_capture_edge #(.STAGES(SYNC_STAGES)) u_cap (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pins[g]),
      .trig_i (trig_sel[g]),
      .event_o(edge_evt[g])
    );

    assign cap_evt[g] = edge_evt[g] & cap_mode[g];
    assign match[g]   = run_q & tick_i & ~cap_mode[g] & ~clr & (cnt == eff[g]);
    assign ovw[g]     = cap_evt[g] & flags_q[2+g];

    pwm_cc_wave u_wave (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .mode_i(out_sel[g]),
      .inv_i (inv_sel[g]),
      .clr_i (clr),
      .set_i (match[0] & ~suppress),
      .rst_i (match[1]),
      .tog_i (match[g]),
      .out_o (pwm[g])
    );
  end

  assign pwm_a_o = pwm[0];
  assign pwm_b_o = pwm[1];

  assign flag_set = {ovw, cap_evt, match};
  assign w1c      = (reg_we_i && reg_addr_i == ADR_FLAGS) ? reg_wdata_i[NFLAG-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      bufen_q <= 1'b0;
      mode_q  <= '0;
      ien_q   <= '0;
      flags_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        cmp_q[i]    <= '0;
        shadow_q[i] <= '0;
      end
    end else begin
      if (reg_we_i && reg_addr_i == ADR_CTRL) begin
        run_q   <= reg_wdata_i[0];
        bufen_q <= reg_wdata_i[2];
      end
      if (reg_we_i && reg_addr_i == ADR_MODE) mode_q <= mode_t'(reg_wdata_i[MODE_W-1:0]);
      if (reg_we_i && reg_addr_i == ADR_IEN)  ien_q  <= reg_wdata_i[NFLAG-1:0];
      flags_q <= (flags_q & ~w1c) | flag_set;
      for (int i = 0; i < NCH; i++) begin
        if (cap_evt[i]) cmp_q[i] <= cnt;
        else if (reg_we_i && reg_addr_i == ADR_CMPA + ADDR_W'(i)) cmp_q[i] <= reg_wdata_i;
        if (!bufen_q || wrap || clr) shadow_q[i] <= cmp_q[i];
      end
    end
  end

  assign irq_o = |(flags_q & ien_q);

  always_comb begin
    unique case (reg_addr_i)
      ADR_CTRL:  reg_rdata_o = {{(CNT_W-3){1'b0}}, bufen_q, 1'b0, run_q};
      ADR_MODE:  reg_rdata_o = {{(CNT_W-MODE_W){1'b0}}, mode_q};
      ADR_CMPA:  reg_rdata_o = cmp_q[0];
      ADR_CMPB:  reg_rdata_o = cmp_q[1];
      ADR_COUNT: reg_rdata_o = cnt;
      ADR_FLAGS: reg_rdata_o = {{(CNT_W-NFLAG){1'b0}}, flags_q};
      ADR_IEN:   reg_rdata_o = {{(CNT_W-NFLAG){1'b0}}, ien_q};
      default:   reg_rdata_o = '0;
    endcase
  end

  a_r9_overwrite_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt[0] && flags_q[2]) |=> flags_q[4]);

  a_r9_overwrite_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_evt[1] && flags_q[3]) |=> flags_q[5]);

  a_r11_w1c_cmp_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADR_FLAGS && reg_wdata_i[0] && !match[0]) |=> !flags_q[0]);

  a_r8_compare_mode_keeps_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_q.cap_a && !(reg_we_i && reg_addr_i == ADR_CMPA)) |=> $stable(cmp_q[0]));

  a_r10_shadow_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bufen_q && !wrap && !clr) |=> $stable(shadow_q[1]));

  a_r4_match_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match[1] |=> flags_q[1]);

endmodule

// File: tb/pwm_cc_timer_tb_top.sv
module pwm_cc_timer_tb_top;
  import pwm_cc_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_ni, tick, cap_a, cap_b, we;
  logic [2:0]  addr;
  logic [15:0] wdata, rdata;
  logic        pwm_a, pwm_b, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  logic [15:0] m_cnt, m_a, m_b;
  logic [5:0]  m_flags;
  logic [1:0]  m_raw, m_inv;
  int          m_out [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_cc_timer dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .cap_a_i(cap_a), .cap_b_i(cap_b),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .pwm_a_o(pwm_a), .pwm_b_o(pwm_b), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [15:0] mw(bit ca, bit cb, logic [1:0] ta, logic [1:0] tb,
                                     logic [1:0] oa, logic [1:0] ob, bit ia, bit ib);
    return {4'b0, ib, ia, ob, oa, tb, ta, cb, ca};
  endfunction

  task automatic cfg(input logic [15:0] a, input logic [15:0] b, input int oa, input int ob,
                     input bit ia, input bit ib);
    wr(ADR_MODE, mw(0, 0, 2'd0, 2'd0, 2'(oa), 2'(ob), ia, ib));
    wr(ADR_CMPA, a);
    wr(ADR_CMPB, b);
    wr(ADR_IEN, 16'h3);
    wr(ADR_FLAGS, 16'h3f);
    wr(ADR_CTRL, 16'h3);
    m_cnt = 0; m_a = a; m_b = b; m_flags = 0; m_raw = 0;
    m_inv = {ib, ia}; m_out[0] = oa; m_out[1] = ob;
  endtask

  // cycle model of counter, compare flags and waveforms
  task automatic run_phase(input int n, input int pct, input string tag);
    logic [15:0] v;
    logic ma, mb;
    for (int c = 0; c < n; c++) begin
      tick = (($urandom % 100) < pct);
      if (tick) begin
        ma = (m_cnt == m_a);
        mb = (m_cnt == m_b);
        m_cnt = mb ? 16'd0 : m_cnt + 16'd1;
        m_flags = m_flags | {4'b0, mb, ma};
        for (int k = 0; k < 2; k++) begin
          case (m_out[k])
            1: if (mb) m_raw[k] = 1'b0; else if (ma && m_a < m_b) m_raw[k] = 1'b1;
            2: if ((k == 0) ? ma : mb) m_raw[k] = ~m_raw[k];
            default: m_raw[k] = 1'b0;
          endcase
        end
      end
      @(negedge clk);
      chk({tag, " out A"}, pwm_a, m_raw[0] ^ m_inv[0]);
      chk({tag, " out B"}, pwm_b, m_raw[1] ^ m_inv[1]);
      rd(ADR_COUNT, v); chk({tag, " count"}, v, m_cnt);
      rd(ADR_FLAGS, v); chk({tag, " flags"}, v, {10'b0, m_flags});
      chk({tag, " irq"}, irq, |m_flags[1:0]);
    end
    tick = 1'b0;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [15:0] v;
    void'($urandom(32'd20240611));
    rst_ni = 0; tick = 0; cap_a = 0; cap_b = 0; we = 0; addr = 0; wdata = 0;
    cyc(3);
    rst_ni = 1;
    @(negedge clk);

    // R1 reset state
    rd(ADR_COUNT, v); chk("R1 count", v, 0);
    rd(ADR_FLAGS, v); chk("R1 flags", v, 0);
    rd(ADR_CTRL, v);  chk("R1 ctrl", v, 0);
    rd(ADR_MODE, v);  chk("R1 mode", v, 0);
    chk("R1 out A", pwm_a, 0);
    chk("R1 out B", pwm_b, 0);
    chk("R1 irq", irq, 0);

    // R2 counting and holding
    wr(ADR_CMPA, 16'hffff);
    wr(ADR_CMPB, 16'hffff);
    wr(ADR_CTRL, 16'h1);
    cyc(3);
    rd(ADR_COUNT, v); chk("R2 no tick holds", v, 0);
    tick = 1; cyc(5); tick = 0;
    rd(ADR_COUNT, v); chk("R2 five ticks", v, 5);
    wr(ADR_CTRL, 16'h0);
    tick = 1; cyc(4); tick = 0;
    rd(ADR_COUNT, v); chk("R2 stopped holds", v, 5);

    // R12 clear
    wr(ADR_CTRL, 16'h2);
    rd(ADR_COUNT, v); chk("R12 cleared", v, 0);
    rd(ADR_CTRL, v);  chk("R12 clear bit reads 0", v, 0);

    // R3 period from B
    wr(ADR_CMPB, 16'd3);
    wr(ADR_CTRL, 16'h3);
    tick = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      rd(ADR_COUNT, v); chk("R3 period 3 sequence", v, 16'((i + 1) % 4));
    end
    tick = 0;

    // R4 compare flags
    wr(ADR_CTRL, 16'h2);
    wr(ADR_CMPA, 16'd2);
    wr(ADR_CMPB, 16'd5);
    wr(ADR_FLAGS, 16'h3f);
    wr(ADR_CTRL, 16'h1);
    tick = 1; cyc(2); tick = 0;
    rd(ADR_FLAGS, v); chk("R4 no flag before match", v, 0);
    tick = 1; cyc(1); tick = 0;
    rd(ADR_FLAGS, v); chk("R4 A match flag", v, 16'h1);
    tick = 1; cyc(3); tick = 0;
    rd(ADR_FLAGS, v); chk("R4 B match flag", v, 16'h3);
    rd(ADR_COUNT, v); chk("R4 wrapped", v, 0);

    // R11 masking and write-1-to-clear
    chk("R11 irq masked", irq, 0);
    wr(ADR_IEN, 16'h2);
    chk("R11 irq enabled", irq, 1);
    wr(ADR_FLAGS, 16'h2);
    rd(ADR_FLAGS, v); chk("R11 clear B only", v, 16'h1);
    chk("R11 irq drops", irq, 0);
    wr(ADR_FLAGS, 16'h0);
    rd(ADR_FLAGS, v); chk("R11 zero write no effect", v, 16'h1);
    wr(ADR_FLAGS, 16'h1);
    rd(ADR_FLAGS, v); chk("R11 clear A", v, 0);

    // R5 set/reset and suppression, R6 toggle and off, R7 inversion
    cfg(16'd2, 16'd5, 1, 1, 0, 1);  run_phase(14, 100, "R5 set/reset");
    cfg(16'd6, 16'd4, 1, 0, 0, 0);  run_phase(20, 100, "R5 suppressed");
    chk("R5 no rise when A>=B", pwm_a, 0);
    cfg(16'd3, 16'd7, 2, 2, 0, 0);  run_phase(20, 100, "R6 toggle");
    cfg(16'd3, 16'd7, 0, 0, 0, 0);  run_phase(10, 100, "R6 off");
    cfg(16'd3, 16'd7, 2, 0, 1, 1);  run_phase(12, 100, "R7 inverted");
    chk("R7 idle inverted high", pwm_b, 1);

    // random mix
    for (int r = 0; r < 10; r++) begin
      cfg(16'($urandom % 12), 16'($urandom % 12), int'($urandom % 3), int'($urandom % 3),
          bit'($urandom % 2), bit'($urandom % 2));
      run_phase(50, 60, "R4 R5 R6 R7 random");
    end

    // R10 buffered compare
    wr(ADR_MODE, 16'h0);
    wr(ADR_CMPA, 16'd2);
    wr(ADR_CMPB, 16'd8);
    wr(ADR_CTRL, 16'h6);
    wr(ADR_CTRL, 16'h5);
    tick = 1; cyc(4); tick = 0;
    wr(ADR_CMPB, 16'd3);
    tick = 1; cyc(4); tick = 0;
    rd(ADR_COUNT, v); chk("R10 old period kept", v, 8);
    tick = 1; cyc(1); tick = 0;
    rd(ADR_COUNT, v); chk("R10 wrap at old period", v, 0);
    tick = 1; cyc(3); tick = 0;
    rd(ADR_COUNT, v); chk("R10 new period reach", v, 3);
    tick = 1; cyc(1); tick = 0;
    rd(ADR_COUNT, v); chk("R10 new period wrap", v, 0);
    wr(ADR_CMPB, 16'd8);
    wr(ADR_CTRL, 16'h3);
    tick = 1; cyc(5); tick = 0;
    wr(ADR_CMPB, 16'd6);
    tick = 1; cyc(2); tick = 0;
    rd(ADR_COUNT, v); chk("R10 unbuffered immediate", v, 0);

    // R3 free-running wrap with B capturing
    wr(ADR_MODE, mw(0, 1, 2'd0, 2'd0, 2'd0, 2'd0, 0, 0));
    wr(ADR_CTRL, 16'h3);
    tick = 1; cyc(65535); tick = 0;
    rd(ADR_COUNT, v); chk("R3 free run top", v, 16'hffff);
    tick = 1; cyc(1); tick = 0;
    rd(ADR_COUNT, v); chk("R3 free run wrap", v, 0);

    // R8 capture, R9 overwrite
    wr(ADR_MODE, mw(1, 1, 2'd1, 2'd3, 2'd0, 2'd0, 0, 0));
    wr(ADR_CTRL, 16'h3);
    tick = 1; cyc(9); tick = 0;
    wr(ADR_CTRL, 16'h0);
    wr(ADR_FLAGS, 16'h3f);
    wr(ADR_CMPA, 16'h1234);
    cap_a = 1; cyc(2);
    rd(ADR_CMPA, v);  chk("R8 not latched early", v, 16'h1234);
    rd(ADR_FLAGS, v); chk("R8 no flag early", v, 0);
    cyc(1);
    rd(ADR_CMPA, v);  chk("R8 rising capture", v, 9);
    rd(ADR_FLAGS, v); chk("R8 capture flag A", v, 16'h4);
    cap_a = 0; cyc(3);
    rd(ADR_FLAGS, v); chk("R8 falling ignored on rise trigger", v, 16'h4);
    cap_a = 1; cyc(3);
    rd(ADR_FLAGS, v); chk("R9 overwrite flag A", v, 16'h14);
    cap_b = 1; cyc(3);
    rd(ADR_CMPB, v);  chk("R8 both-edge rise B", v, 9);
    wr(ADR_CTRL, 16'h1);
    tick = 1; cyc(3); tick = 0;
    wr(ADR_CTRL, 16'h0);
    wr(ADR_FLAGS, 16'h3f);
    cap_b = 0; cyc(3);
    rd(ADR_CMPB, v);  chk("R8 both-edge fall B", v, 12);
    rd(ADR_FLAGS, v); chk("R9 no overwrite after clear", v, 16'h8);
    wr(ADR_MODE, mw(0, 1, 2'd3, 2'd3, 2'd0, 2'd0, 0, 0));
    wr(ADR_CMPA, 16'h55);
    wr(ADR_FLAGS, 16'h3f);
    cap_a = 0; cyc(3);
    rd(ADR_CMPA, v);  chk("R8 comparator ignores edge", v, 16'h55);
    rd(ADR_FLAGS, v); chk("R8 comparator no flag", v, 0);

    done = 1;
    summary();
  end

endmodule